// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Option

This block is an 18-bit word buffer whose write side and read side run on two free-running clocks. The two clocks may be unrelated or may share a source. A word moves on a rising edge of its port's clock, and only when that port's enable is high. The write and read pointers cross between the two domains as Gray codes through synchronizer stages. The full condition is worked out in the write domain and the empty condition in the read domain.

Two mode pins are sampled while reset is held low.

- **Read timing.** In standard timing a word leaves the buffer only when a read is requested. In fall-through timing the oldest word is presented on the output by itself, and a read acknowledges it.
- **Status latency.** One synchronizer stage can be added to both pointer crossings. This delays how soon each side sees the other side's progress.

Besides the two fixed status outputs, the block provides a half-full flag and almost-empty and almost-full flags. The almost flags use offsets that a software-free load sequence on the write port can change.

Top module: `dcfifo_dual`

## Requirements
- R1: While `rst_n` is low, `fwft_sel` and `dbl_sel` are captured. After reset, `rd_flag`=1, `wr_flag`=0, `pae`=1, `paf`=0, `hf`=0 and `dout`=0.
- R2: Words leave the block in the order they were accepted, in both read timings, with unrelated clock frequencies on the two ports.
- R3: In standard timing (`fwft_sel`=0), `dout` changes only on a read-clock edge where `rd_en`=1 and `rd_flag`=0. That edge loads the oldest word. `rd_flag`=1 means no word is stored.
- R4: In fall-through timing (`fwft_sel`=1), `rd_flag`=0 means a valid word is on `dout`, and an edge with `rd_en`=1 consumes it. A word written into an empty block with `dbl_sel`=0 is on `dout` with `rd_flag`=0 right after the third read-clock rising edge that follows the write edge.
- R5: With `dbl_sel`=1 each pointer crossing has one more stage. The fall-through latency of R4 then becomes four read-clock rising edges.
- R6: `pae` is 1 when the stored word count is at most the almost-empty offset. In fall-through timing the word held on `dout` is part of that count. `paf` is 1 when the free memory slots number at most the almost-full offset. Both offsets are 127 after reset.
- R7: `hf` is 1 when more than DEPTH/2 words are in memory.
- R8: `wr_flag` is 1 when memory holds DEPTH words. In fall-through timing one further word waits on `dout`, so the block holds DEPTH+1 words. A write while `wr_flag`=1 is ignored.
- R9: A read while `rd_flag`=1 is ignored. It moves no pointer and leaves `dout` unchanged.
- R10: While `ld`=1, each write-clock edge with `wr_en`=1 takes `din` bits [AW-1:0] as an offset instead of storing a word. The first such edge after reset sets the almost-empty offset, the next sets the almost-full offset, and the sequence then alternates between the two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| fwft_sel | input | 1 | 1 selects fall-through timing (captured in reset) |
| dbl_sel | input | 1 | 1 adds a synchronizer stage (captured in reset) |
| wr_en | input | 1 | Write enable |
| ld | input | 1 | Routes enabled writes to the offset registers |
| din | input | 18 | Write data |
| rd_en | input | 1 | Read enable |
| dout | output | 18 | Read data register |
| rd_flag | output | 1 | Empty (standard) / no word ready (fall-through) |
| wr_flag | output | 1 | Full / not ready for input |
| pae | output | 1 | Almost-empty flag |
| paf | output | 1 | Almost-full flag |
| hf | output | 1 | Half-full flag |

## Verification

**Standard timing.** A read is taken on a read-clock edge. The bench records it against its reference queue at that edge and compares `dout` at the following falling read-clock edge, one register later.

**Fall-through timing.** The queue head is compared against `dout` at every falling read-clock edge while `rd_flag` is 0. The arrival latency is counted as read-clock rising edges after the write edge: three with one synchronizer stage setting and four with the other.

**Flags.** A local operation sets its flag one edge after that operation. A flag driven by the other domain is released only after the synchronizer. The bench therefore checks `pae`, `paf`, `hf`, `wr_flag` and `rd_flag` counts only after twelve read-clock cycles with no traffic.

// File: rtl/dcf_pkg.sv
// Shared constants and types for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package dcf_pkg;

    // Data word width of the buffer.
    parameter int unsigned WORD_W = 18;

    // Which offset register the next load-mode write updates.
    typedef enum logic {
        SLOT_EMPTY_SIDE = 1'b0,
        SLOT_FULL_SIDE  = 1'b1
    } load_slot_e;

    // Read timing chosen at reset.
    typedef enum logic {
        TIMING_STD  = 1'b0,
        TIMING_FALL = 1'b1
    } rd_timing_e;

endpackage

// File: rtl/dcf_ptr_sync.sv
// Brings a Gray-coded pointer into a destination clock domain and converts
// it to binary. Two stages are always present. A third stage is selected
// by `dbl` to lengthen the crossing by one clock.
// Assumes: the source changes the Gray value by at most one bit per source
// clock, and `dbl` is static outside reset.
module dcf_ptr_sync #(
    parameter int unsigned PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] st1, st2, st3;
    logic [PW-1:0] picked;

    // Synchronizer chain, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st1 <= '0;
            st2 <= '0;
            st3 <= '0;
        end else begin
            st1 <= gray_in;
            st2 <= st1;
            st3 <= st2;
        end
    end

    // Stage selection and Gray-to-binary conversion.
    always_comb begin
        picked = dbl ? st3 : st2;
        bin_out[PW-1] = picked[PW-1];
        for (int i = int'(PW) - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ picked[i];
        end
    end

endmodule

// File: rtl/dcf_ram.sv
// Simple dual-port storage: synchronous write on the write clock,
// combinational read addressed from the read domain.
// Assumes: the read address never points at a slot being written in the
// same cycle while that slot is reported as readable.
module dcf_ram #(
    parameter int unsigned DEPTH = 512,
    parameter int unsigned AW    = 9,
    parameter int unsigned WW    = 18
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [WW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [WW-1:0] rdata
);

    logic [WW-1:0] cells [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Asynchronous read port.
    assign rdata = cells[raddr];

endmodule

// File: rtl/dcf_wr_side.sv
// Write-domain control: write pointer (binary and Gray), full detection
// against the synchronized read pointer, the almost-full and half-full
// flags, and the offset load sequencer.
// Assumes: `ld` and offsets are changed only when no traffic depends on
// them. The almost-empty offset is used as a quasi-static value by the
// read side.
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int unsigned DEPTH   = 512,
    parameter int unsigned AW      = 9,
    parameter int unsigned PW      = 10,
    parameter int unsigned DEF_OFF = 127
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl_pin,
    input  logic          wr_en,
    input  logic          ld,
    input  logic [AW-1:0] ld_data,
    input  logic [PW-1:0] rgray,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          full,
    output logic          paf,
    output logic          hf,
    output logic          we,
    output logic [AW-1:0] ae_off
);

    localparam logic [PW-1:0] CAP  = PW'(DEPTH);
    localparam logic [PW-1:0] HALF = PW'(DEPTH / 2);
    localparam logic [AW-1:0] DEF  = AW'(DEF_OFF);

    logic          dbl_q;
    logic [PW-1:0] rsync;
    logic [PW-1:0] used;
    logic [PW-1:0] room;
    logic [PW-1:0] wnext;
    logic [AW-1:0] af_off;
    load_slot_e    slot;

    // Capture the synchronizer-depth choice while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dbl_q <= dbl_pin;
        end
    end

    dcf_ptr_sync #(.PW(PW)) u_rsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbl    (dbl_q),
        .gray_in(rgray),
        .bin_out(rsync)
    );

    // Occupancy and derived flags from registered state.
    always_comb begin
        used  = wbin - rsync;
        room  = CAP - used;
        full  = (used == CAP);
        paf   = (room <= {{(PW-AW){1'b0}}, af_off});
        hf    = (used > HALF);
        we    = wr_en && !ld && !full;
        wnext = wbin + 1'b1;
    end

    // Write pointer, kept in binary and in Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wnext;
            wgray <= wnext ^ (wnext >> 1);
        end
    end

    // Offset load sequencer: alternating empty-side then full-side offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ae_off <= DEF;
            af_off <= DEF;
            slot   <= SLOT_EMPTY_SIDE;
        end else if (ld && wr_en) begin
            unique case (slot)
                SLOT_EMPTY_SIDE: begin
                    ae_off <= ld_data;
                    slot   <= SLOT_FULL_SIDE;
                end
                SLOT_FULL_SIDE: begin
                    af_off <= ld_data;
                    slot   <= SLOT_EMPTY_SIDE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dcf_rd_side.sv
// Read-domain control: read pointer (binary and Gray), empty detection
// against the synchronized write pointer, the output data register with
// standard or fall-through timing, and the almost-empty flag.
// Assumes: `fwft_pin` and `dbl_pin` are static outside reset, and `ae_off`
// is quasi-static.
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int unsigned AW = 9,
    parameter int unsigned PW = 10,
    parameter int unsigned WW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft_pin,
    input  logic          dbl_pin,
    input  logic          rd_en,
    input  logic [PW-1:0] wgray,
    input  logic [WW-1:0] mem_rdata,
    input  logic [AW-1:0] ae_off,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic [AW-1:0] raddr,
    output logic [WW-1:0] dout,
    output logic          rd_flag,
    output logic          pae,
    output logic          fall_q
);

    rd_timing_e    timing_q;
    logic          dbl_q;
    logic [PW-1:0] wsync;
    logic [PW-1:0] rnext;
    logic [PW-1:0] stored;
    logic          mem_empty;
    logic          held;
    logic          take;

    // Capture the mode pins while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= rd_timing_e'(fwft_pin);
            dbl_q    <= dbl_pin;
        end
    end

    dcf_ptr_sync #(.PW(PW)) u_wsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbl    (dbl_q),
        .gray_in(wgray),
        .bin_out(wsync)
    );

    // Fetch decision and status flags.
    always_comb begin
        fall_q    = (timing_q == TIMING_FALL);
        mem_empty = (rbin == wsync);
        if (fall_q) begin
            take    = !mem_empty && (!held || rd_en);
            rd_flag = !held;
        end else begin
            take    = rd_en && !mem_empty;
            rd_flag = mem_empty;
        end
        stored = (wsync - rbin) + {{(PW-1){1'b0}}, (fall_q && held)};
        pae    = (stored <= {{(PW-AW){1'b0}}, ae_off});
        rnext  = rbin + 1'b1;
        raddr  = rbin[AW-1:0];
    end

    // Read pointer, kept in binary and in Gray form.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (take) begin
            rbin  <= rnext;
            rgray <= rnext ^ (rnext >> 1);
        end
    end

    // Output register and its valid bit (the bit is used by fall-through only).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            held <= 1'b0;
        end else if (take) begin
            dout <= mem_rdata;
            held <= 1'b1;
        end else if (rd_en) begin
            held <= 1'b0;
        end
    end

endmodule

// File: rtl/dcfifo_dual.sv
// Top level of the dual-clock FIFO. It joins the write control, the read
// control and the storage array.
// Assumes: DEPTH is a power of two, the offsets fit in AW bits, and reset
// is held low for several cycles of both clocks.
module dcfifo_dual
    import dcf_pkg::*;
#(
    parameter int unsigned DEPTH   = 512,
    parameter int unsigned DEF_OFF = 127
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              fwft_sel,
    input  logic              dbl_sel,
    input  logic              wr_en,
    input  logic              ld,
    input  logic [WORD_W-1:0] din,
    input  logic              rd_en,
    output logic [WORD_W-1:0] dout,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              pae,
    output logic              paf,
    output logic              hf
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic [PW-1:0]     wptr_b, wptr_g;
    logic [PW-1:0]     rptr_b, rptr_g;
    logic              mem_we;
    logic [AW-1:0]     mem_raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic [AW-1:0]     ae_off;
    logic              rd_fall_q;

    dcf_wr_side #(
        .DEPTH  (DEPTH),
        .AW     (AW),
        .PW     (PW),
        .DEF_OFF(DEF_OFF)
    ) u_wr (
        .clk    (wclk),
        .rst_n  (rst_n),
        .dbl_pin(dbl_sel),
        .wr_en  (wr_en),
        .ld     (ld),
        .ld_data(din[AW-1:0]),
        .rgray  (rptr_g),
        .wbin   (wptr_b),
        .wgray  (wptr_g),
        .full   (wr_flag),
        .paf    (paf),
        .hf     (hf),
        .we     (mem_we),
        .ae_off (ae_off)
    );

    dcf_ram #(
        .DEPTH(DEPTH),
        .AW   (AW),
        .WW   (WORD_W)
    ) u_ram (
        .wclk (wclk),
        .we   (mem_we),
        .waddr(wptr_b[AW-1:0]),
        .wdata(din),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

    dcf_rd_side #(
        .AW(AW),
        .PW(PW),
        .WW(WORD_W)
    ) u_rd (
        .clk      (rclk),
        .rst_n    (rst_n),
        .fwft_pin (fwft_sel),
        .dbl_pin  (dbl_sel),
        .rd_en    (rd_en),
        .wgray    (wptr_g),
        .mem_rdata(mem_rdata),
        .ae_off   (ae_off),
        .rbin     (rptr_b),
        .rgray    (rptr_g),
        .raddr    (mem_raddr),
        .dout     (dout),
        .rd_flag  (rd_flag),
        .pae      (pae),
        .fall_q   (rd_fall_q)
    );

endmodule

// File: rtl/dcf_chk.sv
// Protocol checker for dcfifo_dual. It watches the pointers and flags in
// both clock domains.
// Assumes: it is attached through the bind statement at the end of this file.
module dcf_chk #(
    parameter int unsigned PW = 10
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          ld,
    input logic          rd_en,
    input logic          wr_flag,
    input logic          rd_flag,
    input logic          pae,
    input logic          paf,
    input logic          hf,
    input logic          fall_q,
    input logic [PW-1:0] w_ptr,
    input logic [PW-1:0] r_ptr
);

    // R8
    no_overflow_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_flag && wr_en) |=> $stable(w_ptr));

    // R10
    load_no_store_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        (ld && wr_en) |=> $stable(w_ptr));

    // R7
    full_implies_flags_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_flag |-> (hf && paf));

    // R9
    no_underflow_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fall_q && rd_flag && rd_en) |=> $stable(r_ptr));

    // R2
    rd_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (r_ptr != $past(r_ptr)) |-> (r_ptr == PW'($past(r_ptr) + 1'b1)));

    // R6
    empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fall_q && rd_flag) |-> pae);

endmodule

bind dcfifo_dual dcf_chk #(.PW(PW)) u_chk (
    .wclk   (wclk),
    .rclk   (rclk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .ld     (ld),
    .rd_en  (rd_en),
    .wr_flag(wr_flag),
    .rd_flag(rd_flag),
    .pae    (pae),
    .paf    (paf),
    .hf     (hf),
    .fall_q (rd_fall_q),
    .w_ptr  (wptr_b),
    .r_ptr  (rptr_b)
);

// File: tb/dcfifo_dual_tb.sv
`timescale 1ns/1ps
// Self-checking bench. It keeps a behavioural queue model and compares
// against it on every read clock.
module dcfifo_dual_tb;

    localparam int DEPTH = 512;

    logic        wclk = 1'b0;
    logic        rclk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fwft_sel = 1'b0;
    logic        dbl_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        ld = 1'b0;
    logic [17:0] din = '0;
    logic        rd_en = 1'b0;
    logic [17:0] dout;
    logic        rd_flag, wr_flag, pae, paf, hf;

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [17:0] q[$];
    logic [17:0] exp_w;
    bit          pend = 0;
    bit          mon_on = 0;
    bit          fall_m = 0;
    int          seq = 0;
    logic [7:0]  lf = 8'h5a;

    // 125 MHz write clock; the read clock has an unrelated period.
    always #4 wclk = ~wclk;
    initial begin
        #0.025;
        forever #5.85 rclk = ~rclk;
    end

    dcfifo_dual u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .dbl_sel(dbl_sel), .wr_en(wr_en), .ld(ld), .din(din), .rd_en(rd_en),
        .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag), .pae(pae),
        .paf(paf), .hf(hf)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $realtime);
        end
    endtask

    // Write-side model: accept on enabled, non-load, non-full edges.
    always @(posedge wclk) begin
        if (mon_on && wr_en && !ld && !wr_flag) q.push_back(din);
    end

    // Read-side model: consume on an enabled edge while a word is readable.
    always @(posedge rclk) begin
        if (mon_on && rd_en && !rd_flag) begin
            if (q.size() == 0) chk(0, "R2 read with empty model", 1, 0);
            else begin
                exp_w = q.pop_front();
                pend = !fall_m;
            end
        end
    end

    // Per-cycle data comparison, away from the active edge.
    always @(negedge rclk) begin
        if (mon_on) begin
            if (!fall_m && pend) begin
                chk(dout == exp_w, "R2/R3 std data", dout, exp_w);
                pend = 0;
            end else if (fall_m && !rd_flag) begin
                if (q.size() == 0) chk(0, "R4 word shown with empty model", dout, 0);
                else chk(dout == q[0], "R2/R4 fall-through head", dout, q[0]);
            end
        end
    end

    task automatic do_reset(input bit fw, input bit db);
        mon_on = 0; rst_n = 0; fwft_sel = fw; dbl_sel = db; fall_m = fw;
        wr_en = 0; rd_en = 0; ld = 0; pend = 0; q.delete();
        repeat (4) @(negedge rclk);
        rst_n = 1; mon_on = 1;
        @(negedge rclk);
        // R1 reset state
        chk(rd_flag == 1, "R1 rd_flag", rd_flag, 1);
        chk(wr_flag == 0, "R1 wr_flag", wr_flag, 0);
        chk(pae == 1, "R1 pae", pae, 1);
        chk(paf == 0, "R1 paf", paf, 0);
        chk(hf == 0, "R1 hf", hf, 0);
        chk(dout == 0, "R1 dout", dout, 0);
    endtask

    task automatic put(input logic [17:0] d);
        @(negedge wclk); wr_en = 1; din = d;
        @(negedge wclk); wr_en = 0;
    endtask

    function automatic logic [17:0] nextval();
        seq++;
        return 18'(seq * 37 + 5);
    endfunction

    task automatic fill_to(input int n);
        while (q.size() < n) put(nextval());
    endtask

    task automatic settle();
        repeat (12) @(negedge rclk);
    endtask

    task automatic drain();
        for (int k = 0; k < 6000; k++) begin
            @(negedge rclk);
            if (q.size() == 0 && rd_flag) break;
            rd_en = 1;
        end
        rd_en = 0;
        settle();
        chk(rd_flag == 1 && q.size() == 0, "R2 drained", q.size(), 0);
    endtask

    task automatic latency(input int exp_n, input string tag);
        int n = 0;
        @(negedge wclk); wr_en = 1; din = 18'h2bcd;
        @(posedge wclk);
        fork
            begin @(negedge wclk); wr_en = 0; end
            begin
                for (int k = 0; k < 20; k++) begin
                    @(posedge rclk); n++;
                    @(negedge rclk);
                    if (!rd_flag) break;
                end
            end
        join
        chk(n == exp_n, tag, n, exp_n);
        chk(dout == 18'h2bcd, tag, dout, 18'h2bcd);
    endtask

    task automatic stream(input int words);
        fork
            begin
                for (int k = 0; k < words; k++) put(nextval());
            end
            begin
                for (int k = 0; k < words * 2; k++) begin
                    @(negedge rclk);
                    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    rd_en = lf[0] | lf[2];
                end
                rd_en = 0;
            end
        join
        drain();
    endtask

    initial begin
        // Standard timing, two synchronizer stages.
        do_reset(0, 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge rclk); rd_en = 1;
        end
        @(negedge rclk); rd_en = 0;
        chk(dout == 0, "R9 dout after ignored reads", dout, 0);
        put(18'h155);
        settle();
        chk(rd_flag == 0, "R3 rd_flag with one word", rd_flag, 0);
        chk(dout == 0, "R3 dout holds before read", dout, 0);
        @(negedge rclk); rd_en = 1;
        @(negedge rclk); rd_en = 0;
        chk(dout == 18'h155, "R9 R3 word after ignored reads", dout, 18'h155);
        settle();
        chk(rd_flag == 1, "R3 empty again", rd_flag, 1);

        fill_to(127); settle();
        chk(pae == 1, "R6 pae at 127", pae, 1);
        fill_to(128); settle();
        chk(pae == 0, "R6 pae at 128", pae, 0);
        fill_to(256); settle();
        chk(hf == 0, "R7 hf at half", hf, 0);
        fill_to(257); settle();
        chk(hf == 1, "R7 hf above half", hf, 1);
        fill_to(384); settle();
        chk(paf == 0, "R6 paf at 128 free", paf, 0);
        fill_to(385); settle();
        chk(paf == 1, "R6 paf at 127 free", paf, 1);
        fill_to(DEPTH - 1); settle();
        chk(wr_flag == 0, "R8 not full at DEPTH-1", wr_flag, 0);
        fill_to(DEPTH);
        chk(wr_flag == 1, "R8 full at DEPTH", wr_flag, 1);
        put(18'h3ffff); put(18'h3fffe); settle();
        chk(q.size() == DEPTH, "R8 extra writes ignored", q.size(), DEPTH);
        drain();

        // R10 offset loading with wrap-around.
        ld = 1; put(18'd5); put(18'd20); put(18'd10); ld = 0;
        settle();
        chk(rd_flag == 1, "R10 load writes not stored", rd_flag, 1);
        fill_to(10); settle();
        chk(pae == 1, "R10 pae at new offset", pae, 1);
        fill_to(11); settle();
        chk(pae == 0, "R10 pae above new offset", pae, 0);
        fill_to(DEPTH - 21); settle();
        chk(paf == 0, "R10 paf at 21 free", paf, 0);
        fill_to(DEPTH - 20); settle();
        chk(paf == 1, "R10 paf at 20 free", paf, 1);
        drain();

        // Fall-through timing, two stages.
        do_reset(1, 0);
        latency(3, "R4 fall-through latency");
        stream(300);
        for (int k = 0; k < 2000 && q.size() < DEPTH + 1; k++) put(nextval());
        put(nextval()); settle();
        chk(wr_flag == 1, "R8 fall-through full", wr_flag, 1);
        chk(q.size() == DEPTH + 1, "R8 fall-through capacity", q.size(), DEPTH + 1);
        drain();

        // Fall-through timing, three stages.
        do_reset(1, 1);
        latency(4, "R5 double-stage latency");
        stream(200);

        // Standard timing, three stages.
        do_reset(0, 1);
        stream(200);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        #1000000;
        chk(0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule